// File: doc/BRIEF.md
# Frame-Gated Stream Control Unit

This unit sits in a packetized video stream and decides, packet by packet, when the stream may continue. Every packet starts with a header word whose lowest bits give its type. Non-image packets are forwarded as they arrive. An image packet is held at its header until software has set a run flag through a small memory-mapped register port. When the flag is set, the frame is started and its words are forwarded unchanged.

Software tunes the frame through four parameter registers. At the moment a frame starts, the unit copies them into shadow registers, and it drives the shadow copy on an output bus for the whole frame. A write during a frame therefore only takes effect on the next one. A status bit shows whether a frame is currently in progress. Software can pair the run flag with this status bit to change parameters exactly between frames: it clears the flag, waits for status to fall, writes the parameters, then sets the flag again.

Top module: `frame_gate_ctrl`

## Requirements
- R1: Offset 0 holds the run flag in bit 0. It is readable and writable, and its upper bits read as zero.
- R2: A read returns its data and a valid pulse exactly one cycle after the read strobe. A read of any offset above 5 returns zero.
- R3: CLR_DELAY cycles after reset is released, the unit clears the run flag to 0, even if it was written earlier. The stream input is not ready before that point.
- R4: Offset 1 reads the frame-in-progress bit in bit 0, with all other bits zero. Writes to offset 1 have no effect.
- R5: The low 4 bits of a packet's first word give its type. Type 0 is an image packet: its header is not emitted while the run flag is 0, and it is emitted without delay when the flag is already 1. Any other type is forwarded while the flag is 0.
- R6: Once the flag is 1 at an image header, the parameters are copied to `param_out` and status becomes 1. The header and the payload are then emitted in order and unchanged.
- R7: Parameter writes during a frame leave `param_out` unchanged for every beat of that frame. The new values appear at the next frame start.
- R8: Clearing the run flag mid-frame lets the current frame complete. The next image header then stalls until the flag is set again.
- R9: Every accepted input word leaves exactly once, in order. While `out_valid` is high and `out_ready` is low, the output word holds steady.
- R10: Status returns to 0 in the cycle after the last beat (end marker) of an image packet is accepted.
- R11: Offsets 2 to 5 are four 32-bit parameter registers, each readable and writable.
- R12: Input buffering is two words. While a header stalls, at most the header and one more word are accepted, and then `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Register offset |
| csr_wdata | input | REG_W | Write data |
| csr_rdata | output | REG_W | Read data, one cycle after the strobe |
| csr_rvalid | output | 1 | Read data valid |
| in_data | input | DATA_W | Input stream word |
| in_sop | input | 1 | Input first-word marker |
| in_eop | input | 1 | Input last-word marker |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input can accept a word |
| out_data | output | DATA_W | Output stream word |
| out_sop | output | 1 | Output first-word marker |
| out_eop | output | 1 | Output last-word marker |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| param_out | output | NPARAM*REG_W | Shadowed parameters for the current frame |

## Verification
The bench sends non-image packets while the run flag is 0; this shows that only type 0 is gated. It sends image packets in two cases: with the flag at 0, so the header must stall with exactly two words buffered, and with the flag already at 1, so nothing may stall. One frame is frozen mid-way by holding `out_ready` low, and the parameters and the flag are rewritten during it. This separates a design that shadows at frame start from one that forwards live values, and a design that aborts the frame from one that finishes it. The output back-pressure alternates, so stalled words must hold steady. A single-beat image packet and mixed back-to-back packets exercise the header and end-marker corner cases.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  localparam int TYPE_W = 4;

  typedef enum logic [1:0] {
    GS_SOP   = 2'd0,
    GS_PASS  = 2'd1,
    GS_FRAME = 2'd2
  } gate_st_t;

  function automatic logic type_is_image(input logic [TYPE_W-1:0] ptype);
    return ptype == '0;
  endfunction

  function automatic logic slot_hit(input int unsigned addr, input int unsigned slot);
    return addr == slot;
  endfunction

endpackage

// File: rtl/fgc_csr.sv
module fgc_csr #(
  parameter int ADDR_W    = 3,
  parameter int REG_W     = 32,
  parameter int NPARAM    = 4,
  parameter int CLR_DELAY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wdata,
  input  logic                    frame_active,
  output logic [REG_W-1:0]        rdata,
  output logic                    rvalid,
  output logic                    go_bit,
  output logic                    init_done,
  output logic [NPARAM*REG_W-1:0] param_bus
);
  import fgc_pkg::*;

  localparam int PBASE = 2;
  localparam int CW    = $clog2(CLR_DELAY + 1);

  logic [CW-1:0]    clr_cnt;
  logic             go_clr;
  logic [REG_W-1:0] prm [NPARAM];
  logic [REG_W-1:0] rd_word;

  assign go_clr = !init_done && (clr_cnt == CW'(CLR_DELAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_cnt   <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (go_clr) init_done <= 1'b1;
      else        clr_cnt   <= clr_cnt + 1'b1;
    end
  end

  // run flag has no reset value: the sequencer above clears it
  always_ff @(posedge clk) begin
    if (go_clr)
      go_bit <= 1'b0;
    else if (wr_en && slot_hit(int'(addr), 0))
      go_bit <= wdata[0];
  end

  for (genvar i = 0; i < NPARAM; i++) begin : g_prm
    always_ff @(posedge clk) begin
      if (!rst_n)
        prm[i] <= '0;
      else if (wr_en && slot_hit(int'(addr), PBASE + i))
        prm[i] <= wdata;
    end
    assign param_bus[i*REG_W +: REG_W] = prm[i];
  end

  always_comb begin
    rd_word = '0;
    if (slot_hit(int'(addr), 0))
      rd_word[0] = go_bit;
    else if (slot_hit(int'(addr), 1))
      rd_word[0] = frame_active;
    for (int i = 0; i < NPARAM; i++)
      if (slot_hit(int'(addr), PBASE + i)) rd_word = prm[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/fgc_skid.sv
module fgc_skid #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] head_word,
  output logic         head_valid,
  input  logic         pop
);
  logic [W-1:0] slot [2];
  logic         wptr, rptr;
  logic [1:0]   count;
  logic         push;

  assign in_ready   = enable && (count != 2'd2);
  assign push       = in_valid && in_ready;
  assign head_valid = (count != 2'd0);
  assign head_word  = slot[rptr];

  always_ff @(posedge clk) begin
    if (push) slot[wptr] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= 1'b0;
      rptr  <= 1'b0;
      count <= 2'd0;
    end else begin
      if (push) wptr <= ~wptr;
      if (pop)  rptr <= ~rptr;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end

endmodule

// File: rtl/fgc_gate.sv
module fgc_gate #(
  parameter int PW = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      head_valid,
  input  logic                      head_sop,
  input  logic                      head_eop,
  input  logic [fgc_pkg::TYPE_W-1:0] head_type,
  input  logic                      go_bit,
  input  logic                      out_ready,
  input  logic [PW-1:0]             param_bus,
  output logic                      out_valid,
  output logic                      pop,
  output logic                      frame_active,
  output logic                      frame_start,
  output logic                      frame_end,
  output logic [PW-1:0]             param_out
);
  import fgc_pkg::*;

  gate_st_t st, st_nx;
  logic     image_head, pass_ok;

  assign image_head  = head_valid && head_sop && type_is_image(head_type);
  assign frame_start = (st == GS_SOP) && image_head && go_bit;

  always_comb begin
    case (st)
      GS_PASS, GS_FRAME: pass_ok = 1'b1;
      default:           pass_ok = head_valid && !image_head;
    endcase
  end

  assign out_valid    = head_valid && pass_ok;
  assign pop          = out_valid && out_ready;
  assign frame_end    = (st == GS_FRAME) && pop && head_eop;
  assign frame_active = (st == GS_FRAME);

  always_comb begin
    st_nx = st;
    case (st)
      GS_SOP: begin
        if (frame_start)                         st_nx = GS_FRAME;
        else if (pop && head_sop && !head_eop)   st_nx = GS_PASS;
      end
      GS_PASS:  if (pop && head_eop) st_nx = GS_SOP;
      GS_FRAME: if (frame_end)       st_nx = GS_SOP;
      default:                       st_nx = GS_SOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= GS_SOP;
      param_out <= '0;
    end else begin
      st <= st_nx;
      if (frame_start) param_out <= param_bus;
    end
  end

endmodule

// File: rtl/frame_gate_ctrl.sv
module frame_gate_ctrl #(
  parameter int DATA_W    = 24,
  parameter int REG_W     = 32,
  parameter int NPARAM    = 4,
  parameter int ADDR_W    = 3,
  parameter int CLR_DELAY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csr_wr,
  input  logic                    csr_rd,
  input  logic [ADDR_W-1:0]       csr_addr,
  input  logic [REG_W-1:0]        csr_wdata,
  output logic [REG_W-1:0]        csr_rdata,
  output logic                    csr_rvalid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    in_sop,
  input  logic                    in_eop,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_sop,
  output logic                    out_eop,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NPARAM*REG_W-1:0] param_out
);
  localparam int PW = NPARAM * REG_W;
  localparam int SW = DATA_W + 2;

  // named internal events, observed by the bound checker
  logic          go_bit, init_done;
  logic          frame_active, frame_start, frame_end;
  logic          head_valid, pop;
  logic [SW-1:0] head_word;
  logic [PW-1:0] param_bus;

  fgc_csr #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NPARAM(NPARAM), .CLR_DELAY(CLR_DELAY)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .rd_en(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .frame_active(frame_active), .rdata(csr_rdata),
    .rvalid(csr_rvalid), .go_bit(go_bit), .init_done(init_done), .param_bus(param_bus)
  );

  fgc_skid #(.W(SW)) u_skid (
    .clk(clk), .rst_n(rst_n), .enable(init_done),
    .in_word({in_sop, in_eop, in_data}), .in_valid(in_valid), .in_ready(in_ready),
    .head_word(head_word), .head_valid(head_valid), .pop(pop)
  );

  fgc_gate #(.PW(PW)) u_gate (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
    .head_sop(head_word[SW-1]), .head_eop(head_word[SW-2]),
    .head_type(head_word[fgc_pkg::TYPE_W-1:0]), .go_bit(go_bit),
    .out_ready(out_ready), .param_bus(param_bus), .out_valid(out_valid), .pop(pop),
    .frame_active(frame_active), .frame_start(frame_start), .frame_end(frame_end),
    .param_out(param_out)
  );

  assign out_sop  = head_word[SW-1];
  assign out_eop  = head_word[SW-2];
  assign out_data = head_word[DATA_W-1:0];

endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int DATA_W = 24,
  parameter int PW     = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_rd,
  input logic              csr_rvalid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic [DATA_W-1:0] out_data,
  input logic [PW-1:0]     param_out,
  input logic              go_bit,
  input logic              init_done,
  input logic              frame_active,
  input logic              frame_end
);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> csr_rvalid);

  assert_go_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !go_bit);

  assert_no_early_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> init_done);

  assert_header_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && out_data[3:0] == 4'd0) |-> frame_active);

  assert_shadow_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !frame_end) |=> $stable(param_out));

  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_status_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_active);

endmodule

bind frame_gate_ctrl fgc_checker #(.DATA_W(DATA_W), .PW(NPARAM*REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_rvalid(csr_rvalid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_sop(out_sop), .out_data(out_data), .param_out(param_out),
  .go_bit(go_bit), .init_done(init_done), .frame_active(frame_active),
  .frame_end(frame_end)
);

// File: tb/frame_gate_ctrl_test.sv
module frame_gate_ctrl_test;
  localparam int DW = 24, RW = 32, NP = 4, AW = 3;

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0, csr_rd = 0;
  logic [AW-1:0] csr_addr = '0;
  logic [RW-1:0] csr_wdata = '0, csr_rdata;
  logic csr_rvalid;
  logic [DW-1:0] in_data = '0, out_data;
  logic in_sop = 0, in_eop = 0, in_valid = 0, in_ready;
  logic out_sop, out_eop, out_valid, out_ready = 1;
  logic [NP*RW-1:0] param_out;

  always #2.5 clk = ~clk;

  frame_gate_ctrl uut (.*);

  int nchk = 0, nfail = 0, cyc = 0, rmode = 0;
  int hdr_cnt = 0, beat_cnt = 0, acc_cnt = 0;
  bit done = 0, hold_pend = 0, in_img = 0;
  logic [DW+1:0] exp_q[$];
  logic [DW-1:0] held;
  logic [NP*RW-1:0] next_exp = '0, cur_exp = '0, pa, pb;
  logic [RW-1:0] rd;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input int a, input logic [RW-1:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = AW'(a); csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic csr_read(input int a, output logic [RW-1:0] d);
    @(negedge clk); csr_rd = 1; csr_addr = AW'(a);
    @(negedge clk); csr_rd = 0;
    chk(csr_rvalid == 1'b1, "R2 rvalid", 128'(csr_rvalid), 1);
    d = csr_rdata;
  endtask

  task automatic send_pkt(input int ptype, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] w;
      w = DW'(seed * 4099 + i * 257 + 16);
      if (i == 0) w[3:0] = 4'(ptype);
      @(negedge clk);
      in_valid = 1; in_data = w; in_sop = (i == 0); in_eop = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      exp_q.push_back({in_sop, in_eop, in_data});
      acc_cnt++;
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic drain();
    for (int t = 0; t < 3000 && exp_q.size() != 0; t++) @(negedge clk);
    chk(exp_q.size() == 0, "R9 drained", 128'(exp_q.size()), 0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3 != 0);
      default: out_ready <= 1'b0;
    endcase
  end

  // cycle-by-cycle reference: queue of accepted words, shadow expectation
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid && out_data == held, "R9 hold", 128'(out_data), 128'(held));
      hold_pend = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        logic [DW+1:0] e;
        bit img;
        beat_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R9 extra beat", 128'(out_data), 0);
        end else begin
          e = exp_q.pop_front();
          chk({out_sop, out_eop, out_data} == e, "R6 R9 order", 128'({out_sop, out_eop, out_data}), 128'(e));
        end
        img = in_img;
        if (out_sop && out_data[3:0] == 4'd0) begin
          hdr_cnt++; cur_exp = next_exp; img = 1;
        end
        if (img) chk(param_out == cur_exp, "R7 shadow", param_out, cur_exp);
        in_img = img && !out_eop;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      pa[i*RW +: RW] = 32'hA000_0000 + 32'(i * 273);
      pb[i*RW +: RW] = 32'h5B00_0000 + 32'(i * 4369);
    end
    repeat (5) @(negedge clk);
    chk(out_valid == 0 && csr_rvalid == 0 && param_out == '0, "reset state", 128'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0, "R3 input closed during init", 128'(in_ready), 0);
    csr_write(0, 1);
    repeat (10) @(negedge clk);
    csr_read(0, rd); chk(rd == 0, "R3 go cleared", 128'(rd), 0);
    chk(in_ready == 1, "R3 input open", 128'(in_ready), 1);

    csr_read(1, rd); chk(rd == 0, "R4 status idle", 128'(rd), 0);
    csr_write(1, 32'hFFFF_FFFF);
    csr_read(1, rd); chk(rd == 0, "R4 status write ignored", 128'(rd), 0);
    csr_read(7, rd); chk(rd == 0, "R2 unmapped 7", 128'(rd), 0);
    csr_read(6, rd); chk(rd == 0, "R2 unmapped 6", 128'(rd), 0);

    for (int i = 0; i < NP; i++) csr_write(2 + i, pa[i*RW +: RW]);
    for (int i = 0; i < NP; i++) begin
      csr_read(2 + i, rd); chk(rd == pa[i*RW +: RW], "R11 param readback", 128'(rd), 128'(pa[i*RW +: RW]));
    end
    csr_write(0, 32'hFFFF_FFFF);
    csr_read(0, rd); chk(rd == 1, "R1 go set, upper zero", 128'(rd), 1);
    csr_write(0, 0);
    csr_read(0, rd); chk(rd == 0, "R1 go clear", 128'(rd), 0);

    // non-image packets pass with go low
    rmode = 1;
    send_pkt(3, 3, 1);
    send_pkt(5, 1, 2);
    drain();
    chk(beat_cnt == 4, "R5 non-image forwarded", 128'(beat_cnt), 4);

    // image header stalls with go low
    acc_cnt = 0;
    fork send_pkt(0, 4, 3); join_none
    repeat (20) @(negedge clk);
    chk(hdr_cnt == 0, "R5 header held", 128'(hdr_cnt), 0);
    chk(acc_cnt == 2 && in_ready == 0, "R12 two buffered", 128'(acc_cnt), 2);
    csr_read(1, rd); chk(rd == 0, "R4 status while stalled", 128'(rd), 0);
    next_exp = pa;
    csr_write(0, 1);
    wait fork;
    drain();
    chk(hdr_cnt == 1, "R6 frame released", 128'(hdr_cnt), 1);
    csr_read(1, rd); chk(rd == 0, "R10 status after frame", 128'(rd), 0);

    // go already set: no wait
    send_pkt(0, 3, 4);
    drain();
    chk(hdr_cnt == 2, "R5 go already set", 128'(hdr_cnt), 2);

    // mid-frame parameter write and go clear
    rmode = 2;
    fork send_pkt(0, 6, 5); join_none
    repeat (10) @(negedge clk);
    csr_read(1, rd); chk(rd == 1, "R4 R6 status in frame", 128'(rd), 1);
    for (int i = 0; i < NP; i++) csr_write(2 + i, pb[i*RW +: RW]);
    csr_write(0, 0);
    rmode = 1;
    wait fork;
    drain();
    chk(hdr_cnt == 3 && beat_cnt == 17, "R8 frame completed", 128'(beat_cnt), 17);
    csr_read(1, rd); chk(rd == 0, "R10 status low", 128'(rd), 0);

    fork send_pkt(0, 3, 6); join_none
    repeat (20) @(negedge clk);
    chk(hdr_cnt == 3, "R8 next header stalls", 128'(hdr_cnt), 3);
    next_exp = pb;
    csr_write(0, 1);
    wait fork;
    drain();
    chk(hdr_cnt == 4, "R7 new params next frame", 128'(hdr_cnt), 4);

    // mixed back-to-back, single-beat image
    rmode = 0;
    send_pkt(0, 2, 7);
    send_pkt(9, 2, 8);
    send_pkt(0, 1, 9);
    drain();
    chk(hdr_cnt == 6 && beat_cnt == 25, "R6 mixed and single-beat", 128'(beat_cnt), 25);
    csr_read(1, rd); chk(rd == 0, "R10 after single-beat", 128'(rd), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule